// File: doc/BRIEF.md
# Line Mapper Reset and Alarm-Clear Controller

This block holds the reset logic and the control registers of a four-port line mapper. It takes an active-low hardware reset pin and a simple single-cycle register write port. From them it drives clear strobes for the performance counters, FIFO recentering and alarm logic of every port. It also drives an alarm-clear strobe for each of the two add buses, high-impedance controls for the add buses and line interfaces, and enables for the bus indicator and add-enable outputs. It keeps the per-port loss-of-pointer alarm flags as well. A valid-pointer input clears those flags.

There are three reset levels. A full reset comes from the pin or from a software command. It returns every control bit to its reset value, puts all outputs into their safe state and raises every clear strobe. A per-port partial reset recenters the FIFO, clears the counters and clears the alarms of one port. It also raises that port's loss-of-pointer flags. A counter-only reset clears just the counters of the selected ports. Every command bit clears itself. A write of 1 starts the action and nothing needs to be written back.

Register map: 0x10 bus control, 0x11 line control, 0x15 full reset command, 0x16 port reset commands, 0x17 bus alarm-clear commands. A write to any other address or bit has no effect.

Top module: `mapper_reset_ctl`

## Requirements
- R1: While `rst_pin_n` is low, the outputs are held in their safe state, starting without waiting for a clock edge. In that state `addbus_hiz`, `line_hiz`, every clear strobe and both loss-of-pointer vectors are all ones, and `ind_en` and `add_en` are zero.
- R2: After `rst_pin_n` rises, the safe state continues for exactly MIN_CYC+2 more rising clock edges (2 synchronizer stages plus ceil(150 ns × clock MHz / 1000) = 15 at 100 MHz). This holds for any low pulse, even one that falls between two clock edges.
- R3: Writing 0x15 with bit 7 set gives the same safe state for exactly MIN_CYC cycles, starting with the edge that takes the write. Control bits then return to their reset values. Writing 0x15 with bit 7 clear does nothing.
- R4: Address 0x10 holds bits [1:0] for add-bus A/B high-Z, [3:2] for indicator enable A/B and [5:4] for add enable A/B. Address 0x11 bits [3:0] set the high-Z control of line ports 0..3. The high-Z bits reset to 1 and stay at 1 until 0 is written. The enables reset to 0. Outputs follow a write on the edge that takes it.
- R5: Writing 0x16 with bit p set (p = 0..3) pulses `cnt_clr[p]`, `fifo_recenter[p]` and `port_alm_clr[p]` high for exactly one cycle after the write edge, for that port only. Control bits are left unchanged.
- R6: The same partial reset sets `lop_alarm_a[p]` and `lop_alarm_b[p]`. A flag is cleared on the edge that samples its `ptr_valid_a`/`ptr_valid_b` bit high. If a set and a clear arrive on the same edge, the set wins.
- R7: Writing 0x16 with bit 4+p set pulses only `cnt_clr[p]` for one cycle. Several ports named in one write pulse in the same cycle.
- R8: Writing 0x17 bit 0 or bit 1 pulses `bus_alm_clr[0]` (bus A) or `bus_alm_clr[1]` (bus B) for one cycle, each independently of the other.
- R9: Any write sampled while a full reset is in effect is dropped. This includes a write on the last edge of that full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_pin_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| ptr_valid_a | input | NPORT | Valid pointer seen on bus A, per port |
| ptr_valid_b | input | NPORT | Valid pointer seen on bus B, per port |
| addbus_hiz | output | 2 | Add-bus data high-Z, bit 0 bus A, bit 1 bus B |
| line_hiz | output | NPORT | Line interface high-Z, per port |
| ind_en | output | 2 | Bus indicator output enable, A and B |
| add_en | output | 2 | Bus add-enable output drive, A and B |
| cnt_clr | output | NPORT | Performance counter clear, per port |
| fifo_recenter | output | NPORT | FIFO recenter, per port |
| port_alm_clr | output | NPORT | Port alarm clear, per port |
| bus_alm_clr | output | 2 | Bus alarm clear, A and B |
| lop_alarm_a | output | NPORT | Loss-of-pointer alarm, bus A side, per port |
| lop_alarm_b | output | NPORT | Loss-of-pointer alarm, bus B side, per port |

## Verification
The assertions assume that `wr_en` lasts one cycle and that only one address is written per cycle. That is why a pulse on `fifo_recenter` without a full-reset pattern can be traced back to a write to 0x16 on the previous edge. They also assume that all four recenter strobes together with both bus strobes high can only mean a full reset. No single software write can produce that pattern, and the stimulus never tries to. The bench changes inputs only at falling clock edges. The exception is a deliberately short reset pin pulse placed between edges, which the asynchronous path must still catch.

// File: rtl/mapper_reset_ctl.sv
module mapper_reset_ctl #(
  parameter int NPORT      = 4,
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int CLK_MHZ    = 100,
  parameter int MIN_RST_NS = 150
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [NPORT-1:0] ptr_valid_a,
  input  logic [NPORT-1:0] ptr_valid_b,
  output logic [1:0]       addbus_hiz,
  output logic [NPORT-1:0] line_hiz,
  output logic [1:0]       ind_en,
  output logic [1:0]       add_en,
  output logic [NPORT-1:0] cnt_clr,
  output logic [NPORT-1:0] fifo_recenter,
  output logic [NPORT-1:0] port_alm_clr,
  output logic [1:0]       bus_alm_clr,
  output logic [NPORT-1:0] lop_alarm_a,
  output logic [NPORT-1:0] lop_alarm_b
);
  localparam int MIN_CYC = (MIN_RST_NS * CLK_MHZ + 999) / 1000;
  localparam int CW      = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] HOLD_DONE = CW'(MIN_CYC);
  localparam logic [AW-1:0] A_BUS  = AW'('h10);
  localparam logic [AW-1:0] A_LINE = AW'('h11);
  localparam logic [AW-1:0] A_FULL = AW'('h15);
  localparam logic [AW-1:0] A_PORT = AW'('h16);
  localparam logic [AW-1:0] A_BALM = AW'('h17);
  localparam int FULL_BIT = 7;
  localparam int CRST_LSB = DW / 2;

  logic [1:0]       sync_q;
  logic [CW-1:0]    hold_q;
  logic             fr, wr_ok, sw_full;
  logic [NPORT-1:0] prst_cmd, crst_cmd, prst_q, crst_q, lhz_q, la_q, lb_q;
  logic [1:0]       bclr_cmd, bclr_q, ahz_q, ind_q, add_q;

  assign fr       = (hold_q != HOLD_DONE);
  assign wr_ok    = wr_en & ~fr;
  assign sw_full  = wr_ok & (wr_addr == A_FULL) & wr_data[FULL_BIT];
  assign prst_cmd = (wr_ok && wr_addr == A_PORT) ? wr_data[NPORT-1:0] : '0;
  assign crst_cmd = (wr_ok && wr_addr == A_PORT) ? wr_data[CRST_LSB +: NPORT] : '0;
  assign bclr_cmd = (wr_ok && wr_addr == A_BALM) ? wr_data[1:0] : '0;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) sync_q <= '0;
    else            sync_q <= {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n)            hold_q <= '0;
    else if (sw_full)          hold_q <= '0;
    else if (sync_q[1] && fr)  hold_q <= hold_q + 1'b1;

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      ahz_q <= 2'b11; lhz_q <= '1; ind_q <= '0; add_q <= '0;
    end else if (fr) begin
      ahz_q <= 2'b11; lhz_q <= '1; ind_q <= '0; add_q <= '0;
    end else begin
      if (wr_ok && wr_addr == A_BUS) {add_q, ind_q, ahz_q} <= wr_data[5:0];
      if (wr_ok && wr_addr == A_LINE) lhz_q <= wr_data[NPORT-1:0];
    end

  always_ff @(posedge clk or negedge rst_pin_n)
    if (!rst_pin_n) begin
      prst_q <= '0; crst_q <= '0; bclr_q <= '0;
    end else begin
      prst_q <= prst_cmd; crst_q <= crst_cmd; bclr_q <= bclr_cmd;
    end

  for (genvar p = 0; p < NPORT; p++) begin : g_lop
    always_ff @(posedge clk or negedge rst_pin_n)
      if (!rst_pin_n) begin
        la_q[p] <= 1'b1; lb_q[p] <= 1'b1;
      end else if (fr || prst_cmd[p]) begin
        la_q[p] <= 1'b1; lb_q[p] <= 1'b1;
      end else begin
        if (ptr_valid_a[p]) la_q[p] <= 1'b0;
        if (ptr_valid_b[p]) lb_q[p] <= 1'b0;
      end
  end

  assign addbus_hiz    = ahz_q | {2{fr}};
  assign line_hiz      = lhz_q | {NPORT{fr}};
  assign ind_en        = ind_q & ~{2{fr}};
  assign add_en        = add_q & ~{2{fr}};
  assign cnt_clr       = prst_q | crst_q | {NPORT{fr}};
  assign fifo_recenter = prst_q | {NPORT{fr}};
  assign port_alm_clr  = prst_q | {NPORT{fr}};
  assign bus_alm_clr   = bclr_q | {2{fr}};
  assign lop_alarm_a   = la_q | {NPORT{fr}};
  assign lop_alarm_b   = lb_q | {NPORT{fr}};
endmodule

module mapper_reset_ctl_chk #(
  parameter int NPORT = 4,
  parameter int AW    = 8
) (
  input logic             clk,
  input logic             rst_pin_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [NPORT-1:0] ptr_valid_a,
  input logic [1:0]       addbus_hiz,
  input logic [NPORT-1:0] line_hiz,
  input logic [1:0]       ind_en,
  input logic [1:0]       add_en,
  input logic [NPORT-1:0] cnt_clr,
  input logic [NPORT-1:0] fifo_recenter,
  input logic [NPORT-1:0] port_alm_clr,
  input logic [1:0]       bus_alm_clr,
  input logic [NPORT-1:0] lop_alarm_a
);
  logic full_pat;
  assign full_pat = (&fifo_recenter) && (&bus_alm_clr);

  always @(posedge clk)
    if (!rst_pin_n)
      p_safe_on_pin_r1: assert ((&addbus_hiz) && (&line_hiz) && ind_en == '0 && add_en == '0 && (&cnt_clr));

  p_full_safe_r3: assert property (@(posedge clk) disable iff (!rst_pin_n)
    full_pat |-> ((&addbus_hiz) && (&line_hiz) && ind_en == '0 && add_en == '0));

  p_hiz_hold_r4: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!$past(wr_en) && !full_pat) |-> ($stable(addbus_hiz) && $stable(line_hiz)));

  p_recenter_cause_r5: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((|fifo_recenter) && !full_pat) |-> $past(wr_en && wr_addr == AW'('h16)));

  p_recenter_implies_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((fifo_recenter & ~(cnt_clr & port_alm_clr)) == '0));

  p_lop_set_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((fifo_recenter & ~lop_alarm_a) == '0));

  p_lop_clear_r6: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (($past(ptr_valid_a) & ~fifo_recenter & lop_alarm_a) == '0));
endmodule

bind mapper_reset_ctl mapper_reset_ctl_chk #(.NPORT(NPORT), .AW(AW)) u_chk (.*);

// File: tb/mapper_reset_ctl_bench.sv
module mapper_reset_ctl_bench;
  localparam int MIN = (150 * 100 + 999) / 1000;
  localparam logic [31:0] SAFE = {2'b11, 4'hF, 2'b00, 2'b00, 4'hF, 4'hF, 4'hF, 2'b11, 4'hF, 4'hF};

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [3:0] ptr_valid_a = '0, ptr_valid_b = '0;
  logic [1:0] addbus_hiz, ind_en, add_en, bus_alm_clr;
  logic [3:0] line_hiz, cnt_clr, fifo_recenter, port_alm_clr, lop_alarm_a, lop_alarm_b;

  always #5 clk = ~clk;

  mapper_reset_ctl u_mapper_reset_ctl (.*);

  wire [31:0] obs = {addbus_hiz, line_hiz, ind_en, add_en, cnt_clr, fifo_recenter,
                     port_alm_clr, bus_alm_clr, lop_alarm_a, lop_alarm_b};

  int n_cmp = 0, n_bad = 0, fr_left = 10000;
  bit done = 0;
  logic [31:0] exp_q[$];
  string req_q[$];
  logic [1:0] m_ahz = 2'b11, m_ind = '0, m_add = '0;
  logic [3:0] m_lhz = 4'hF, m_la = 4'hF, m_lb = 4'hF;

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) compare(obs, exp_q.pop_front(), req_q.pop_front());
  end

  task automatic model_push(input logic we, input logic [7:0] a, input logic [7:0] d,
                            input logic [3:0] pa, input logic [3:0] pb, input string req);
    logic frn, ok, fra;
    logic [3:0] ps, cs;
    logic [1:0] bs;
    frn = (fr_left > 0);
    ok  = we && !frn;
    ps  = (ok && a == 8'h16) ? d[3:0] : 4'h0;
    cs  = (ok && a == 8'h16) ? d[7:4] : 4'h0;
    bs  = (ok && a == 8'h17) ? d[1:0] : 2'b00;
    if (ok && a == 8'h15 && d[7]) fr_left = MIN;
    else if (fr_left > 0) fr_left--;
    if (frn) begin
      m_ahz = 2'b11; m_lhz = 4'hF; m_ind = '0; m_add = '0; m_la = 4'hF; m_lb = 4'hF;
    end else begin
      if (ok && a == 8'h10) {m_add, m_ind, m_ahz} = d[5:0];
      if (ok && a == 8'h11) m_lhz = d[3:0];
      m_la = ps | (m_la & ~pa);
      m_lb = ps | (m_lb & ~pb);
    end
    fra = (fr_left > 0);
    exp_q.push_back(fra ? SAFE : {m_ahz, m_lhz, m_ind, m_add, ps | cs, ps, ps, bs, m_la, m_lb});
    req_q.push_back(req);
  endtask

  task automatic cyc(input logic pin, input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic [3:0] pa, input logic [3:0] pb, input string req);
    @(negedge clk);
    if (!pin) fr_left = 10000;
    else if (!rst_pin_n) fr_left = MIN + 2;
    rst_pin_n = pin; wr_en = we; wr_addr = a; wr_data = d;
    ptr_valid_a = pa; ptr_valid_b = pb;
    model_push(we, a, d, pa, pb, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    cyc(1'b1, 1'b1, a, d, 4'h0, 4'h0, req);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 8'h00, 8'h00, 4'h0, 4'h0, "R1 pin held low");
    idle(MIN + 3, "R2 release stretch");
    wr(8'h10, 8'h3C, "R4 bus control write");
    wr(8'h11, 8'h05, "R4 line control write");
    idle(1, "R4 hold");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 4'b0011, 4'b1000, "R6 valid pointer clears");
    idle(1, "R6 hold");
    cyc(1'b1, 1'b1, 8'h16, 8'h05, 4'b0011, 4'b0100, "R5 R6 partial reset, set beats clear");
    idle(2, "R5 single cycle");
    wr(8'h16, 8'hA0, "R7 counter reset ports 1 and 3");
    idle(1, "R7 single cycle");
    wr(8'h16, 8'h31, "R5 R7 mixed port command");
    idle(1, "R7 hold");
    wr(8'h17, 8'h01, "R8 bus A clear");
    idle(1, "R8 hold");
    wr(8'h17, 8'h02, "R8 bus B clear");
    wr(8'h17, 8'h03, "R8 both buses");
    idle(1, "R8 hold");
    wr(8'h15, 8'h7F, "R3 full bit clear has no effect");
    idle(1, "R3 no effect");
    wr(8'h15, 8'h80, "R3 software full reset");
    wr(8'h10, 8'h3C, "R9 write dropped during full reset");
    wr(8'h16, 8'h0F, "R9 command dropped during full reset");
    idle(MIN - 3, "R3 full reset window");
    wr(8'h11, 8'h00, "R9 write on last full reset edge dropped");
    idle(2, "R3 control back to reset values");
    wr(8'h10, 8'h3C, "R4 rewrite after full reset");
    wr(8'h11, 8'h00, "R4 line enable all");
    idle(1, "R4 hold");
    @(negedge clk);
    #1 rst_pin_n = 1'b0;
    #1 compare(obs, SAFE, "R1 asynchronous assertion");
    #1 rst_pin_n = 1'b1;
    m_ahz = 2'b11; m_lhz = 4'hF; m_ind = '0; m_add = '0; m_la = 4'hF; m_lb = 4'hF;
    fr_left = MIN + 2;
    model_push(1'b0, 8'h00, 8'h00, 4'h0, 4'h0, "R2 short pulse");
    idle(MIN + 3, "R2 short pulse stretch");
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 4'hF, 4'hF, "R6 clear all pointers");
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 8'h10, 8'h3C, 4'h0, 4'h0, "R1 pin low ignores writes");
    idle(MIN + 3, "R2 second release");
    @(posedge clk);
    #4;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule